// File: doc/BRIEF.md
# Stereo ADC Serial Output Port

This block takes a pair of parallel 18-bit converter samples, one for the left channel and one for the right, and sends them out as a single serial data line. The line is framed by a shift clock and a left/right framing clock. The framing clock is high while the left word is on the line and low while the right word is on the line. A 3-bit mode word picks one of eight fixed combinations of three settings: clock role (master or slave), word length (16 or 18 bits) and bit order (MSB first or LSB first).

In master mode the block divides its master clock by `SCLK_DIV` to make the shift clock. It places `SLOTS` shift-clock periods in each framing-clock phase and drives both clocks out. In slave mode it takes both clocks from outside, passes them through synchronizers into the master-clock domain, and follows their edges.

Serial data changes just after a falling shift-clock edge, so a receiver samples it on the rising edge. New samples are taken in with a one-cycle valid strobe. They are copied into the shift words only when a left phase begins, so a word never changes while it is being sent. A low `run` input powers the port down. The framing clock, the shift clock and the data line are then all held low.

Top module: `stereo_ser_port`

## Requirements
- R1: The mode word is decoded as follows.
  - `000` and `010`: slave, up to 18 bits, MSB first.
  - `001`: slave, 18 bits, LSB first.
  - `011` and `110`: master, 16 bits, MSB first.
  - `100`: master, 18 bits, MSB first.
  - `101`: master, 18 bits, LSB first.
  - `111`: master, 16 bits, LSB first.
- R2: In master mode `sclk_o` has a period of `SCLK_DIV` master-clock cycles and is high for `SCLK_DIV/2` of them.
- R3: In master mode each `lrclk_o` phase lasts exactly `SLOTS` (default 32) shift-clock periods. `lrclk_o` is high for the left word and low for the right word, and it changes only while `sclk_o` is low.
- R4: `sdata` changes only right after a falling shift-clock edge and stays stable across the following rising edge.
- R5: In 18-bit MSB-first modes, slot k of a phase (k = 0 is the first slot) carries sample bit 17-k for k < 18. Later slots are low.
- R6: In 16-bit modes only sample bits 17..2 are sent and the two low bits are dropped. With MSB first, slot k carries bit 17-k for k < 16. Later slots are low.
- R7: In LSB-first modes slot k carries bit k (18-bit) or bit k+2 (16-bit) while k is below the word length. Later slots are low.
- R8: `smp_l`/`smp_r` are captured when `smp_vld` is high. The captured pair is copied into the shift words only at the first slot of a left phase. A strobe during a frame does not change the frame in progress.
- R9: While `run` is low, `lrclk_o`, `sclk_o` and `sdata` are low from the next clock on. When `run` returns high, master framing restarts and later frames are correct.
- R10: In slave modes `sclk_o` and `lrclk_o` stay low. A left phase starts at the first falling edge of `sclk_in` seen with `lrclk_in` high, and a right phase starts at the first falling edge seen with `lrclk_in` low. Bits are placed by slot as in R5 and R7.
- R11: In slave modes a receiver may give fewer than 18 shift clocks per phase and receives the leading slots of the word. Slots past the word length are low.
- R12: A synchronous active-high `rst` drives `sclk_o`, `lrclk_o` and `sdata` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Role / width / order select (R1) |
| run | input | 1 | High = active, low = digital power-down |
| smp_l | input | 18 | Left-channel sample |
| smp_r | input | 18 | Right-channel sample |
| smp_vld | input | 1 | Capture strobe for `smp_l`/`smp_r` |
| sclk_in | input | 1 | External shift clock (slave modes) |
| lrclk_in | input | 1 | External framing clock (slave modes) |
| sclk_o | output | 1 | Generated shift clock (master modes) |
| lrclk_o | output | 1 | Generated framing clock (master modes) |
| sdata | output | 1 | Serial data |

## Verification
In master mode, `sdata` for a slot is loaded in the same master-clock cycle in which `sclk_o` falls. It is therefore checked `SCLK_DIV/2` cycles later, when the monitor sees `sclk_o` rise.

In slave mode, `sdata` follows an external falling edge after about three master clocks: two synchronizer stages plus the output register. The bench holds each shift-clock half period for six master clocks, so the value is settled before it is sampled on the rising edge.

A sample pair strobed a few cycles after the start of frame n is expected in frame n+1. The scoreboard tags each expected pair with that frame number, and the monitor compares a whole captured frame only when its number matches the tag at the head of the queue. Power-down is checked from the first clock after `run` falls.

// File: rtl/sdo_pkg.sv
package sdo_pkg;

    localparam int SAMPLE_W = 18;
    localparam int SHORT_W  = 16;
    localparam int SLOT_W   = 6;

    // decoded configuration carried through the datapath
    typedef struct packed {
        logic master;
        logic short_word;
        logic lsb_first;
    } port_cfg_t;

    // one shift event: the slot that begins after a falling shift-clock edge
    typedef struct packed {
        logic              tick;
        logic              left;
        logic [SLOT_W-1:0] slot;
    } slot_evt_t;

    function automatic port_cfg_t decode_mode(input logic [2:0] m);
        port_cfg_t c;
        case (m)
            3'b000:  c = '{master: 1'b0, short_word: 1'b0, lsb_first: 1'b0};
            3'b001:  c = '{master: 1'b0, short_word: 1'b0, lsb_first: 1'b1};
            3'b010:  c = '{master: 1'b0, short_word: 1'b0, lsb_first: 1'b0};
            3'b011:  c = '{master: 1'b1, short_word: 1'b1, lsb_first: 1'b0};
            3'b100:  c = '{master: 1'b1, short_word: 1'b0, lsb_first: 1'b0};
            3'b101:  c = '{master: 1'b1, short_word: 1'b0, lsb_first: 1'b1};
            3'b110:  c = '{master: 1'b1, short_word: 1'b1, lsb_first: 1'b0};
            default: c = '{master: 1'b1, short_word: 1'b1, lsb_first: 1'b1};
        endcase
        return c;
    endfunction

    // bit of the sample that a given slot carries, zero past the word
    function automatic logic pick_bit(input logic [SAMPLE_W-1:0] word,
                                      input logic [SLOT_W-1:0]   slot,
                                      input port_cfg_t           cfg);
        int width;
        int idx;
        width = cfg.short_word ? SHORT_W : SAMPLE_W;
        if (int'(slot) >= width) return 1'b0;
        if (cfg.lsb_first) idx = int'(slot) + (SAMPLE_W - width);
        else               idx = SAMPLE_W - 1 - int'(slot);
        return word[idx];
    endfunction

endpackage

// File: rtl/sdo_master_clk.sv
module sdo_master_clk
    import sdo_pkg::*;
#(
    parameter int SCLK_DIV = 8,
    parameter int SLOTS    = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    output logic      sclk_o,
    output logic      lrclk_o,
    output slot_evt_t evt
);
    localparam int HALF = SCLK_DIV / 2;
    localparam int CW   = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int BCW  = $clog2(2 * SLOTS);

    logic [CW-1:0]  div_cnt;
    logic [BCW-1:0] bit_cnt;
    logic [BCW-1:0] nxt_bit;
    logic           wrap;

    assign wrap    = (div_cnt == CW'(SCLK_DIV - 1));
    assign nxt_bit = bit_cnt + 1'b1;

    // idle state: divider at zero (clock low), slot counter on the last right slot
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt <= '0;
            bit_cnt <= '1;
        end else if (wrap) begin
            div_cnt <= '0;
            bit_cnt <= nxt_bit;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign sclk_o   = (div_cnt >= CW'(HALF));
    assign lrclk_o  = ~bit_cnt[BCW-1];
    assign evt.tick = en && wrap;
    assign evt.left = ~nxt_bit[BCW-1];
    assign evt.slot = SLOT_W'(nxt_bit[BCW-2:0]);

    assert_lr_edge_on_low_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(lrclk_o) |-> !sclk_o);

    assert_sclk_fall_loads_slot_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) && $past(en) && en |-> $past(evt.tick));

endmodule

// File: rtl/sdo_slave_track.sv
module sdo_slave_track
    import sdo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      sclk_in,
    input  logic      lrclk_in,
    output slot_evt_t evt
);
    logic [1:0]        sck_sync;
    logic [1:0]        lr_sync;
    logic              sck_d;
    logic              lr_cur;
    logic [SLOT_W-1:0] slot_q;
    logic              fall;
    logic              new_phase;
    logic              at_max;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= '0;
            lr_sync  <= '0;
            sck_d    <= 1'b0;
        end else begin
            sck_sync <= {sck_sync[0], sclk_in};
            lr_sync  <= {lr_sync[0], lrclk_in};
            sck_d    <= sck_sync[1];
        end
    end

    assign fall      = sck_d & ~sck_sync[1];
    assign new_phase = (lr_sync[1] != lr_cur);
    assign at_max    = (slot_q == '1);

    // slot count saturates, so clocks past the word give zeros
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lr_cur <= 1'b0;
            slot_q <= '1;
        end else if (fall) begin
            if (new_phase) begin
                lr_cur <= lr_sync[1];
                slot_q <= '0;
            end else if (!at_max) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign evt.tick = en && fall;
    assign evt.left = lr_sync[1];
    assign evt.slot = new_phase ? '0 : (at_max ? slot_q : slot_q + 1'b1);

    assert_slot_saturates_R11: assert property (@(posedge clk) disable iff (rst)
        (en && at_max && !new_phase) |=> (slot_q == '1));

endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter
    import sdo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  port_cfg_t           cfg,
    input  slot_evt_t           evt,
    input  logic [SAMPLE_W-1:0] pend_l,
    input  logic [SAMPLE_W-1:0] pend_r,
    output logic                sdata
);
    logic [SAMPLE_W-1:0] cur_l;
    logic [SAMPLE_W-1:0] cur_r;
    logic [SAMPLE_W-1:0] word;
    logic                start;

    assign start = evt.tick && evt.left && (evt.slot == '0);
    assign word  = !evt.left ? cur_r : (start ? pend_l : cur_l);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_l <= '0;
            cur_r <= '0;
            sdata <= 1'b0;
        end else if (!run) begin
            sdata <= 1'b0;
        end else if (evt.tick) begin
            if (start) begin
                cur_l <= pend_l;
                cur_r <= pend_r;
            end
            sdata <= pick_bit(word, evt.slot, cfg);
        end
    end

    assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_l) || !$stable(cur_r) |-> $past(start));

    assert_data_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> $past(evt.tick) || !$past(run));

endmodule

// File: rtl/stereo_ser_port.sv
module stereo_ser_port
    import sdo_pkg::*;
#(
    parameter int SCLK_DIV = 8,
    parameter int SLOTS    = 32
) (
    input  logic        mclk,
    input  logic        rst,
    input  logic [2:0]  mode,
    input  logic        run,
    input  logic [17:0] smp_l,
    input  logic [17:0] smp_r,
    input  logic        smp_vld,
    input  logic        sclk_in,
    input  logic        lrclk_in,
    output logic        sclk_o,
    output logic        lrclk_o,
    output logic        sdata
);
    port_cfg_t           cfg;
    slot_evt_t           m_evt;
    slot_evt_t           s_evt;
    slot_evt_t           evt;
    logic [SAMPLE_W-1:0] pend_l;
    logic [SAMPLE_W-1:0] pend_r;

    assign cfg = decode_mode(mode);

    always_ff @(posedge mclk) begin
        if (rst) begin
            pend_l <= '0;
            pend_r <= '0;
        end else if (smp_vld) begin
            pend_l <= smp_l;
            pend_r <= smp_r;
        end
    end

    sdo_master_clk #(.SCLK_DIV(SCLK_DIV), .SLOTS(SLOTS)) u_mclk (
        .clk     (mclk),
        .rst     (rst),
        .en      (run && cfg.master),
        .sclk_o  (sclk_o),
        .lrclk_o (lrclk_o),
        .evt     (m_evt)
    );

    sdo_slave_track u_strk (
        .clk      (mclk),
        .rst      (rst),
        .en       (run && !cfg.master),
        .sclk_in  (sclk_in),
        .lrclk_in (lrclk_in),
        .evt      (s_evt)
    );

    assign evt = cfg.master ? m_evt : s_evt;

    sdo_shifter u_shf (
        .clk    (mclk),
        .rst    (rst),
        .run    (run),
        .cfg    (cfg),
        .evt    (evt),
        .pend_l (pend_l),
        .pend_r (pend_r),
        .sdata  (sdata)
    );

    assert_pd_quiet_R9: assert property (@(posedge mclk) disable iff (rst)
        !$past(run) |-> !lrclk_o && !sclk_o && !sdata);

    assert_slave_clocks_low_R10: assert property (@(posedge mclk) disable iff (rst)
        $past(!cfg.master) && !cfg.master |-> !sclk_o && !lrclk_o);

    assert_reset_quiet_R12: assert property (@(posedge mclk)
        $past(rst) |-> !lrclk_o && !sclk_o && !sdata);

endmodule

// File: tb/test_stereo_ser_port.sv
`timescale 1ns/1ps
module test_stereo_ser_port;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int NSLOT      = 32;

    typedef struct {
        int          tag;
        logic [2:0]  m;
        logic [17:0] l;
        logic [17:0] r;
        int          slots;
        string       req;
    } item_t;

    logic        mclk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'b100;
    logic        run = 1'b0;
    logic [17:0] smp_l = '0;
    logic [17:0] smp_r = '0;
    logic        smp_vld = 1'b0;
    logic        sclk_in = 1'b1;
    logic        lrclk_in = 1'b0;
    logic        sclk_o, lrclk_o, sdata;

    int    n_checks = 0;
    int    n_errors = 0;
    int    frame_no = 0;
    int    sl_bits = 24;
    bit    slv_run = 1'b0;
    bit    done = 1'b0;
    item_t q[$];

    stereo_ser_port #(.SCLK_DIV(DIV), .SLOTS(NSLOT)) i_stereo_ser_port (
        .mclk(mclk), .rst(rst), .mode(mode), .run(run),
        .smp_l(smp_l), .smp_r(smp_r), .smp_vld(smp_vld),
        .sclk_in(sclk_in), .lrclk_in(lrclk_in),
        .sclk_o(sclk_o), .lrclk_o(lrclk_o), .sdata(sdata)
    );

    always #(CLK_PERIOD/2) mclk = ~mclk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // R1: independent model of the mode table
    function automatic bit is_master(input logic [2:0] m);
        return m >= 3'b011;
    endfunction

    function automatic logic exp_bit(input logic [2:0] m, input logic [17:0] w, input int s);
        int width;
        bit lsb;
        width = (m == 3'b011 || m == 3'b110 || m == 3'b111) ? 16 : 18;
        lsb   = (m == 3'b001 || m == 3'b101 || m == 3'b111);
        if (s >= width) return 1'b0;
        return lsb ? w[s + 18 - width] : w[17 - s];
    endfunction

    // monitor: captures frames and compares against the scoreboard queue
    logic [63:0] cap_l, cap_r;
    int  nl, nr;
    bit  in_frame = 1'b0;
    bit  sck_p = 1'b0, lr_p = 1'b0;

    always @(negedge mclk) begin
        bit sck, lrk;
        logic [63:0] el, er;
        sck = is_master(mode) ? sclk_o : sclk_in;
        lrk = is_master(mode) ? lrclk_o : lrclk_in;
        if (rst) begin
            in_frame = 1'b0;
        end else begin
            if (lrk && !lr_p) begin
                if (in_frame && q.size() > 0 && q[0].tag == frame_no) begin
                    item_t it;
                    it = q.pop_front();
                    el = '0; er = '0;
                    for (int k = 0; k < it.slots; k++) begin
                        el[k] = exp_bit(it.m, it.l, k);
                        er[k] = exp_bit(it.m, it.r, k);
                    end
                    check(nl == it.slots && cap_l == el, it.req,
                          $sformatf("left word mode %b count %0d", it.m, nl), cap_l, el);
                    check(nr == it.slots && cap_r == er, it.req,
                          $sformatf("right word mode %b count %0d", it.m, nr), cap_r, er);
                end
                frame_no++;
                in_frame = 1'b1;
                nl = 0; nr = 0; cap_l = '0; cap_r = '0;
            end
            if (sck && !sck_p && in_frame) begin
                if (lrk) begin if (nl < 64) cap_l[nl] = sdata; nl++; end
                else     begin if (nr < 64) cap_r[nr] = sdata; nr++; end
            end
        end
        sck_p = sck;
        lr_p  = lrk;
    end

    // slave clock source: lrclk changes together with a falling sclk
    initial forever begin
        if (!slv_run) @(posedge mclk);
        else begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int i = 0; i < sl_bits; i++) begin
                    @(posedge mclk); #1;
                    sclk_in = 1'b0;
                    if (i == 0) lrclk_in = (ph == 0);
                    repeat (6) @(posedge mclk); #1;
                    sclk_in = 1'b1;
                    repeat (5) @(posedge mclk);
                end
            end
        end
    end

    // driver: strobes a pair early in frame n and expects it in frame n+1
    task automatic send(input logic [17:0] l, input logic [17:0] r,
                        input int slots, input string req);
        item_t it;
        int f0;
        f0 = frame_no;
        while (frame_no == f0) @(negedge mclk);
        repeat (4) @(negedge mclk);
        smp_l = l; smp_r = r; smp_vld = 1'b1;
        it.tag = frame_no + 1; it.m = mode; it.l = l; it.r = r;
        it.slots = slots; it.req = req;
        q.push_back(it);
        @(negedge mclk);
        smp_vld = 1'b0;
    endtask

    task automatic disturb(input logic [17:0] l, input logic [17:0] r);
        int f0;
        f0 = frame_no;
        while (frame_no == f0) @(negedge mclk);
        repeat (6) @(negedge mclk);
        smp_l = l; smp_r = r; smp_vld = 1'b1;
        @(negedge mclk);
        smp_vld = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge mclk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge mclk); run = 1'b0;
        repeat (3) @(negedge mclk);
        mode = m;
        @(negedge mclk); run = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge mclk);
        check(1'b0, "watchdog", "run did not end", 64'd0, 64'd1);
        finish_up();
    end

    initial begin
        int hi, lo;
        bit quiet;
        repeat (5) @(negedge mclk);
        // R12: reset state
        check(!sclk_o && !lrclk_o && !sdata, "R12", "outputs in reset",
              {61'd0, sclk_o, lrclk_o, sdata}, 64'd0);
        rst = 1'b0;
        @(negedge mclk);
        check(!sclk_o && !lrclk_o && !sdata, "R12", "outputs after reset",
              {61'd0, sclk_o, lrclk_o, sdata}, 64'd0);

        // mode 100: master, 18 bits, MSB first
        set_mode(3'b100);
        // R2: shift clock high time and period
        while (sclk_o) @(negedge mclk);
        while (!sclk_o) @(negedge mclk);
        hi = 0; lo = 0;
        while (sclk_o) begin hi++; @(negedge mclk); end
        while (!sclk_o) begin lo++; @(negedge mclk); end
        check(hi == DIV/2, "R2", "sclk high cycles", 64'(hi), 64'(DIV/2));
        check(hi + lo == DIV, "R2", "sclk period", 64'(hi + lo), 64'(DIV));

        send(18'h2A5C3, 18'h15A3C, NSLOT, "R3 R5");
        send(18'h3FFFF, 18'h00001, NSLOT, "R3 R5");
        // R8: a strobe inside frame n+1 must not disturb that frame
        send(18'h12345, 18'h2BCDE, NSLOT, "R8");
        disturb(18'h3F0F0, 18'h00F0F);
        send(18'h00155, 18'h3AAAA, NSLOT, "R8");
        drain();

        // R9: power-down holds all outputs low
        @(negedge mclk); run = 1'b0;
        @(negedge mclk);
        quiet = 1'b1;
        for (int i = 0; i < 3 * DIV; i++) begin
            if (sclk_o || lrclk_o || sdata) quiet = 1'b0;
            @(negedge mclk);
        end
        check(quiet, "R9", "outputs low in power-down", {63'd0, quiet}, 64'd1);
        run = 1'b1;
        send(18'h1C3A5, 18'h25A5A, NSLOT, "R9");
        drain();

        set_mode(3'b101);
        send(18'h2A5C3, 18'h15A3C, NSLOT, "R7");
        send(18'h00003, 18'h30000, NSLOT, "R7");
        drain();
        set_mode(3'b011);
        send(18'h2A5C3, 18'h15A3F, NSLOT, "R1 R6");
        drain();
        set_mode(3'b111);
        send(18'h2A5C3, 18'h15A3F, NSLOT, "R6 R7");
        send(18'h00007, 18'h3FFFC, NSLOT, "R6 R7");
        drain();
        set_mode(3'b110);
        send(18'h3C00F, 18'h0FFF3, NSLOT, "R1 R6");
        drain();

        // slave modes
        @(negedge mclk); run = 1'b0;
        mode = 3'b000; sl_bits = 24;
        repeat (3) @(negedge mclk);
        run = 1'b1; slv_run = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (sclk_o || lrclk_o) quiet = 1'b0;
            @(negedge mclk);
        end
        check(quiet, "R10", "slave mode clock outputs low", {63'd0, quiet}, 64'd1);
        send(18'h2A5C3, 18'h15A3C, 24, "R1 R10");
        send(18'h3FFFF, 18'h20001, 24, "R10");
        drain();
        slv_run = 1'b0;
        repeat (700) @(negedge mclk);

        @(negedge mclk); run = 1'b0;
        mode = 3'b001; sl_bits = 18;
        repeat (3) @(negedge mclk);
        run = 1'b1; slv_run = 1'b1;
        send(18'h2A5C3, 18'h0F0F1, 18, "R7 R10");
        drain();
        slv_run = 1'b0;
        repeat (700) @(negedge mclk);

        @(negedge mclk); run = 1'b0;
        mode = 3'b010; sl_bits = 12;
        repeat (3) @(negedge mclk);
        run = 1'b1; slv_run = 1'b1;
        send(18'h2A5C3, 18'h15A3C, 12, "R1 R11");
        send(18'h3FFFF, 18'h3F03F, 12, "R11");
        drain();
        slv_run = 1'b0;

        repeat (20) @(negedge mclk);
        finish_up();
    end
endmodule